// File: doc/BRIEF.md
# Reset NOP-Slide Boot Controller

This block sits between an 8-bit processor's bus and its memory decoders. After reset the processor starts fetching at address 0, but the 2 KB boot ROM is decoded only at the top of memory. Rather than mirroring the ROM into low memory, the controller answers every read with the byte 0x00. The processor executes that byte as a no-operation, so its program counter walks upward until it reaches the ROM base. The first read at or above the base flips a single phase flag. From that point on, the normal ROM/RAM decode serves every access until the next reset.

The ROM base comes from a jumper input and is either 0xF800 or 0xF000. When it is 0xF000, the 2 KB image appears twice in the 4 KB window above the base. RAM fills everything below the base.

The interface is a plain strobe bus: one read or write strobe per clock, and data and selects settle within the same cycle. There is no valid/ready handshake and no back-pressure. The processor never waits, and the controller never stalls it.

Top module: `nop_slide_boot`

## Requirements
- R1: While reset is asserted and directly after it, the phase flag is clear, no chip select or write enable is active, and `cpu_rdata` is 0x00 whenever `cpu_rd` is low.
- R2: In the slide phase, a read at an address below the selected base returns 0x00, and both `rom_cs` and `ram_cs` stay low.
- R3: The first read at an address greater than or equal to the base already returns ROM data, with `rom_cs` high. That same read sets the phase flag on its clock edge. A write at or above the base does not set the flag.
- R4: Once set, the flag holds until reset. A read below the base then drives `ram_cs` high and returns `ram_rdata`.
- R5: When `base_sel` is 0 the base is 0xF800. When it is 1 the base is 0xF000.
- R6: Writes in the slide phase assert neither `ram_cs` nor `ram_we`. After the flag is set, a write below the base asserts both. A write at or above the base asserts no select.
- R7: When ROM is selected, `rom_addr` equals bits [10:0] of (address minus base). In the 0xF000 setting, therefore, 0xF800 to 0xFFFF map onto the same image as 0xF000 to 0xF7FF.
- R8: At most one of `rom_cs` and `ram_cs` is high in any cycle, and neither is high without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | Processor address bus |
| cpu_rd | input | 1 | Read strobe, one access per cycle |
| cpu_wr | input | 1 | Write strobe, one access per cycle |
| base_sel | input | 1 | Jumper: 0 selects base 0xF800, 1 selects base 0xF000 |
| rom_rdata | input | 8 | Byte returned by the boot ROM |
| ram_rdata | input | 8 | Byte returned by the RAM |
| cpu_rdata | output | 8 | Read data to the processor |
| rom_cs | output | 1 | ROM chip select (reads only) |
| rom_addr | output | 11 | Byte offset into the ROM |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |

## Verification
Assertions check on every cycle that:
- the flag is sticky;
- a qualifying read always sets it;
- the selects stay quiet and the data is 0x00 during the slide;
- the selects never overlap.

Only the bench's scenarios can show the end-to-end behaviour. It models a program counter stepping from zero under both jumper settings and confirms that exactly the addresses below the base read as 0x00. It also confirms that the first read at the base returns the ROM's first byte. Directed cases cover:
- arming from above the base rather than exactly at it;
- a write that must not arm the flag;
- the mirrored ROM image;
- RAM access after arming, checked under randomized traffic.

// File: rtl/nsb_pkg.sv
package nsb_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int ROM_AW = 11;
  localparam logic [ADDR_W-1:0] BASE_HIGH = 16'hF800;
  localparam logic [ADDR_W-1:0] BASE_LOW  = 16'hF000;
  localparam logic [DATA_W-1:0] NOP_BYTE  = 8'h00;

  typedef enum logic {
    PH_SLIDE = 1'b0,
    PH_RUN   = 1'b1
  } phase_e;
endpackage

// File: rtl/boot_base_sel.sv
module boot_base_sel
  import nsb_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int RW = ROM_AW,
  parameter logic [AW-1:0] BASE_A = BASE_HIGH,
  parameter logic [AW-1:0] BASE_B = BASE_LOW
) (
  input  logic [AW-1:0] addr,
  input  logic          sel,
  output logic          upper,
  output logic [RW-1:0] rom_off
);
  logic [AW-1:0] base;
  logic [AW-1:0] diff;

  always_comb begin
    base    = sel ? BASE_B : BASE_A;
    upper   = (addr >= base);
    diff    = addr - base;
    rom_off = diff[RW-1:0];
  end
endmodule

// File: rtl/boot_phase_flag.sv
module boot_phase_flag
  import nsb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   arm_req,
  output phase_e phase
);
  always_ff @(posedge clk) begin
    if (rst)          phase <= PH_SLIDE;
    else if (arm_req) phase <= PH_RUN;
  end

  // R4: once running, only reset returns the block to the slide phase
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN) |=> (phase == PH_RUN));

  // R3: an arming request always lands on the next edge
  a_r3_flag_sets: assert property (@(posedge clk) disable iff (rst)
    arm_req |=> (phase == PH_RUN));
endmodule

// File: rtl/boot_bus_route.sv
module boot_bus_route
  import nsb_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_e        phase,
  input  logic          upper,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] rom_data,
  input  logic [DW-1:0] ram_data,
  output logic          arm_req,
  output logic          rom_cs,
  output logic          ram_cs,
  output logic          ram_we,
  output logic [DW-1:0] rdata
);
  logic live;

  always_comb begin
    arm_req = rd && upper && (phase == PH_SLIDE);
    live    = (phase == PH_RUN) || arm_req;
    rom_cs  = live && rd && upper;
    ram_cs  = (phase == PH_RUN) && (rd || wr) && !upper;
    ram_we  = ram_cs && wr;
    rdata   = NOP_BYTE;
    if (rom_cs)           rdata = rom_data;
    else if (ram_cs && rd) rdata = ram_data;
  end

  // R2: during the slide, a low read returns the forced byte
  a_r2_slide_nop: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SLIDE && rd && !upper) |-> (rdata == NOP_BYTE));

  // R2 / R6: no device is selected while sliding below the base
  a_r6_slide_quiet: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SLIDE && !upper) |-> (!ram_cs && !rom_cs && !ram_we));

  // R8: selects never overlap and need a strobe
  a_r8_cs_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_cs, ram_cs}) && ((rom_cs || ram_cs) -> (rd || wr)));
endmodule

// File: rtl/nop_slide_boot.sv
module nop_slide_boot
  import nsb_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int RW = ROM_AW,
  parameter logic [AW-1:0] BASE_A = BASE_HIGH,
  parameter logic [AW-1:0] BASE_B = BASE_LOW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic          base_sel,
  input  logic [DW-1:0] rom_rdata,
  input  logic [DW-1:0] ram_rdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          rom_cs,
  output logic [RW-1:0] rom_addr,
  output logic          ram_cs,
  output logic          ram_we
);
  logic   upper;
  logic   arm_req;
  phase_e phase;

  boot_base_sel #(.AW(AW), .RW(RW), .BASE_A(BASE_A), .BASE_B(BASE_B)) u_base (
    .addr    (cpu_addr),
    .sel     (base_sel),
    .upper   (upper),
    .rom_off (rom_addr)
  );

  boot_phase_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .arm_req (arm_req),
    .phase   (phase)
  );

  boot_bus_route #(.DW(DW)) u_route (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .upper    (upper),
    .rd       (cpu_rd),
    .wr       (cpu_wr),
    .rom_data (rom_rdata),
    .ram_data (ram_rdata),
    .arm_req  (arm_req),
    .rom_cs   (rom_cs),
    .ram_cs   (ram_cs),
    .ram_we   (ram_we),
    .rdata    (cpu_rdata)
  );

  // R3: a ROM-selected read carries ROM data on the bus
  a_r3_rom_data: assert property (@(posedge clk) disable iff (rst)
    (rom_cs && cpu_rd) |-> (cpu_rdata == rom_rdata));

  // R1 / R8: idle bus returns the forced byte
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rd) |-> (cpu_rdata == NOP_BYTE));
endmodule

// File: tb/tb_nop_slide_boot.sv
module tb_nop_slide_boot;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic        base_sel = 1'b0;
  logic [7:0]  rom_rdata, ram_rdata, cpu_rdata;
  logic        rom_cs, ram_cs, ram_we;
  logic [10:0] rom_addr;

  int checks = 0;
  int errors = 0;
  bit exp_run = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [10:0] off);
    return off[7:0] ^ {off[10:8], 5'b10101} ^ 8'h3C;
  endfunction
  function automatic logic [7:0] ram_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hC3;
  endfunction
  function automatic logic [15:0] base_of(input logic s);
    return s ? 16'hF000 : 16'hF800;
  endfunction

  assign rom_rdata = rom_byte(rom_addr);
  assign ram_rdata = ram_byte(cpu_addr);

  nop_slide_boot dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .base_sel(base_sel), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
    .cpu_rdata(cpu_rdata), .rom_cs(rom_cs), .rom_addr(rom_addr),
    .ram_cs(ram_cs), .ram_we(ram_we)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // One bus access: drive at negedge, sample 2 ns later, flag model updates at posedge
  task automatic access(input logic [15:0] a, input bit rd, input bit wr, input string req);
    logic [15:0] b;
    bit up, live;
    logic [7:0] ed;
    logic [10:0] off;
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
    #2;
    b    = base_of(base_sel);
    up   = (a >= b);
    off  = 11'(a - b);
    live = exp_run || (rd && up);
    ed   = 8'h00;
    if (rd && up && live) ed = rom_byte(off);
    else if (rd && !up && exp_run) ed = ram_byte(a);
    chk(req, {24'd0, cpu_rdata}, {24'd0, ed});
    chk(req, {29'd0, rom_cs, ram_cs, ram_we},
        {29'd0, (rd && up && live), (exp_run && !up && (rd || wr)), (exp_run && !up && wr)});
    if (rd && up) chk(req, {21'd0, rom_addr}, {21'd0, off});
    if (rd && up) exp_run = 1'b1;
  endtask

  task automatic do_reset(input logic sel);
    @(negedge clk);
    rst = 1'b1; cpu_rd = 0; cpu_wr = 0; base_sel = sel;
    @(negedge clk); @(negedge clk);
    #2;
    chk("R1", {29'd0, rom_cs, ram_cs, ram_we}, 32'd0);
    chk("R1", {24'd0, cpu_rdata}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    exp_run = 1'b0;
    #2;
    chk("R1", {29'd0, rom_cs, ram_cs, ram_we}, 32'd0);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231003));
    // R5 base 0xF800: program-counter sweep, R2 for every address below base
    do_reset(1'b0);
    for (int pc = 0; pc < 16'hF800; pc++) begin
      access(16'(pc), 1'b1, 1'b0, "R2");
      if (pc % 8192 == 100) access(16'(pc), 1'b0, 1'b1, "R6");
    end
    access(16'hF800, 1'b1, 1'b0, "R3");
    chk("R3", {24'd0, cpu_rdata}, {24'd0, rom_byte(11'd0)});
    // R4 sticky flag, RAM below base; random traffic
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a = 16'($urandom);
      bit w = ($urandom % 3) == 0;
      access(a, !w, w, "R4");
    end
    access(16'h0000, 1'b1, 1'b0, "R4");
    access(16'h0123, 1'b0, 1'b1, "R6");
    access(16'hFA00, 1'b0, 1'b1, "R6");

    // R3 directed: write above base must not arm, read above base arms
    do_reset(1'b0);
    access(16'hF900, 1'b0, 1'b1, "R3");
    access(16'h0010, 1'b1, 1'b0, "R3");
    access(16'hFC00, 1'b1, 1'b0, "R3");
    access(16'h0010, 1'b1, 1'b0, "R4");

    // R5 base 0xF000 sweep, then R7 mirror
    do_reset(1'b1);
    for (int pc = 0; pc < 16'hF000; pc++) access(16'(pc), 1'b1, 1'b0, "R5");
    access(16'hF000, 1'b1, 1'b0, "R5");
    chk("R5", {24'd0, cpu_rdata}, {24'd0, rom_byte(11'd0)});
    access(16'hF805, 1'b1, 1'b0, "R7");
    chk("R7", {21'd0, rom_addr}, 32'd5);
    access(16'hEFFF, 1'b1, 1'b0, "R4");
    for (int i = 0; i < 200; i++) begin
      logic [15:0] a = 16'($urandom);
      access(a, 1'b1, 1'b0, "R8");
    end
    // R8 idle: no strobe, no select, zero data
    access(16'hF800, 1'b0, 1'b0, "R8");
    access(16'h0400, 1'b0, 1'b0, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule